// File: doc/BRIEF.md
# Transfer Request Submission Register File

This block is the memory-mapped front end of a transfer engine. Software writes a 16-word, 32-bit transfer descriptor into one of four register sets. The block then passes the descriptor to a downstream request queue as a valid/ready stream. Each descriptor carries a channel number and the index of the destination queue that the channel selects.

Set 0 is atomic: a descriptor goes out only when one write burst covers all sixteen words. A burst that ends with words missing is dropped and raises a sticky error flag. Sets 1 to 3 are staged: they may be filled over any number of bursts, and a write to word 0 launches the descriptor. After a launch, the staged set returns to all zeros.

The write bus marks the first and last write of each burst. The first write of a burst also chooses the register set and the channel for the whole burst. While a finished descriptor waits at the output, the write bus is stalled.

Top module: `tr_submit_regs`

## Requirements
- R1: After reset, `td_valid` is 0, `atomic_err` is 0 and `wr_ready` is 1.
- R2: The fields of `wr_addr` are: word index in bits [3:0], register set in bits [5:4], channel in bits [9:6]. Set 0 is atomic and sets 1, 2 and 3 are staged. A burst starts with a write that has `wr_sof` high, or with any write when no burst is open, and it ends with a write that has `wr_eof` high. The set and channel of the burst come from its starting write. The set and channel bits of later writes in the same burst are ignored.
- R3: When an atomic burst has written all 16 words by its closing write, one descriptor is issued. Descriptor word i is the last value written to word i in that burst and sits in bits [32i+31:32i] of `td_desc`.
- R4: When an atomic burst closes with fewer than 16 distinct words written, no descriptor is issued and `atomic_err` goes to 1. It stays at 1 until reset.
- R5: Staged sets keep their words across bursts. A write of word 0 to a staged set issues a descriptor. Its word 0 is the written data. Every other word holds the last value written to it since that set's previous launch, or 0 if it was not written.
- R6: When a staged set launches, all of its words clear to 0.
- R7: `td_chan` is the channel of the burst that produced the descriptor. `td_queue` is that channel modulo 5, giving five queues numbered 0 to 4.
- R8: While `td_valid` is 1 and `td_ready` is 0, `wr_ready` is 0 and the descriptor, channel and queue outputs stay unchanged.
- R9: A descriptor appears on `td_valid` in the cycle after its launching write is accepted. With `td_ready` held at 1, back-to-back launches are accepted on consecutive cycles.
- R10: The three staged sets are independent: writes to one never change the contents of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_sof | input | 1 | First write of a burst |
| wr_eof | input | 1 | Last write of a burst |
| wr_addr | input | 10 | Channel, register set and word index |
| wr_data | input | 32 | Write data |
| td_valid | output | 1 | Descriptor available |
| td_ready | input | 1 | Downstream accepts descriptor |
| td_desc | output | 512 | Descriptor, word 0 in the low bits |
| td_chan | output | 4 | Channel of the descriptor |
| td_queue | output | 3 | Destination queue, 0 to 4 |
| atomic_err | output | 1 | Sticky flag for an incomplete atomic burst |

## Verification
The assertions rely on the write requester keeping address, data and burst markers steady while `wr_ready` is low. They also assume that `wr_sof` is only meaningful on an accepted write. The stimulus tasks hold every write field until the handshake completes, and they change inputs only on the falling clock edge. The downstream ready signal follows always-on, always-off and pseudo-random patterns, so the stall path runs while launches are pending. Bursts are built to cover complete, incomplete, repeated-word and mixed-field cases.

// File: rtl/tr_sub_pkg.sv
package tr_sub_pkg;
    localparam int unsigned TRS_DW      = 32;
    localparam int unsigned TRS_WORDS   = 16;
    localparam int unsigned TRS_CH_W    = 4;
    localparam int unsigned TRS_NUM_Q   = 5;
    localparam int unsigned TRS_NA_SETS = 3;
    // index of the register set that requires a whole descriptor per burst
    localparam int unsigned ATOMIC_SET  = 0;
endpackage

// File: rtl/tr_sub_burst.sv
module tr_sub_burst
    import tr_sub_pkg::*;
#(
    parameter int unsigned SW    = 2,
    parameter int unsigned CH_W  = 4,
    parameter int unsigned WW    = 4,
    parameter int unsigned WORDS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic            sof,
    input  logic            eof,
    input  logic [SW-1:0]   set_in,
    input  logic [CH_W-1:0] chan_in,
    input  logic [WW-1:0]   word_in,
    output logic [SW-1:0]   set_o,
    output logic [CH_W-1:0] chan_o,
    output logic            atomic_ok,
    output logic            atomic_bad,
    output logic            err_o
);
    typedef struct packed {
        logic             open;
        logic [SW-1:0]    set;
        logic [CH_W-1:0]  chan;
        logic [WORDS-1:0] mask;
        logic             err;
    } burst_st_t;

    burst_st_t st_d, st_q;
    logic [WORDS-1:0] mask_nxt;
    logic start;

    always_comb begin
        st_d       = st_q;
        start      = sof || !st_q.open;
        set_o      = start ? set_in  : st_q.set;
        chan_o     = start ? chan_in : st_q.chan;
        mask_nxt   = start ? '0 : st_q.mask;
        atomic_ok  = 1'b0;
        atomic_bad = 1'b0;
        if (set_o == SW'(ATOMIC_SET)) begin
            mask_nxt[word_in] = 1'b1;
        end
        if (fire) begin
            st_d.open = 1'b1;
            st_d.set  = set_o;
            st_d.chan = chan_o;
            st_d.mask = mask_nxt;
            if (eof) begin
                st_d.open = 1'b0;
                st_d.mask = '0;
                if (set_o == SW'(ATOMIC_SET)) begin
                    if (&mask_nxt) atomic_ok  = 1'b1;
                    else           atomic_bad = 1'b1;
                end
            end
        end
        st_d.err = st_q.err | atomic_bad;
        err_o    = st_q.err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tr_sub_bank.sv
module tr_sub_bank #(
    parameter int unsigned DW    = 32,
    parameter int unsigned WORDS = 16,
    parameter int unsigned WW    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic                clr,
    input  logic [WW-1:0]       word,
    input  logic [DW-1:0]       data,
    output logic [WORDS*DW-1:0] image
);
    logic [WORDS-1:0][DW-1:0] mem_d, mem_q, merged;

    always_comb begin
        merged = mem_q;
        if (we) merged[word] = data;
        mem_d = clr ? '0 : merged;
        image = merged;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end
endmodule

// File: rtl/tr_sub_out.sv
module tr_sub_out #(
    parameter int unsigned DW    = 32,
    parameter int unsigned WORDS = 16,
    parameter int unsigned CH_W  = 4,
    parameter int unsigned NUM_Q = 5,
    parameter int unsigned QW    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [WORDS*DW-1:0] desc,
    input  logic [CH_W-1:0]     chan,
    input  logic                td_ready,
    output logic                td_valid,
    output logic [WORDS*DW-1:0] td_desc,
    output logic [CH_W-1:0]     td_chan,
    output logic [QW-1:0]       td_queue,
    output logic                busy
);
    typedef struct packed {
        logic                valid;
        logic [WORDS*DW-1:0] desc;
        logic [CH_W-1:0]     chan;
        logic [QW-1:0]       queue;
    } out_st_t;

    out_st_t st_d, st_q;
    int unsigned qsel;

    always_comb begin
        st_d = st_q;
        qsel = 32'(chan) % NUM_Q;
        if (st_q.valid && td_ready) st_d.valid = 1'b0;
        if (load) begin
            st_d.valid = 1'b1;
            st_d.desc  = desc;
            st_d.chan  = chan;
            st_d.queue = QW'(qsel);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign td_valid = st_q.valid;
    assign td_desc  = st_q.desc;
    assign td_chan  = st_q.chan;
    assign td_queue = st_q.queue;
    assign busy     = st_q.valid && !td_ready;
endmodule

// File: rtl/tr_submit_regs.sv
module tr_submit_regs
    import tr_sub_pkg::*;
#(
    parameter int unsigned DW      = TRS_DW,
    parameter int unsigned WORDS   = TRS_WORDS,
    parameter int unsigned CH_W    = TRS_CH_W,
    parameter int unsigned NUM_Q   = TRS_NUM_Q,
    parameter int unsigned NA_SETS = TRS_NA_SETS,
    localparam int unsigned WW     = $clog2(WORDS),
    localparam int unsigned SETS   = NA_SETS + 1,
    localparam int unsigned SW     = $clog2(SETS),
    localparam int unsigned QW     = $clog2(NUM_Q),
    localparam int unsigned AW     = CH_W + SW + WW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    output logic                wr_ready,
    input  logic                wr_sof,
    input  logic                wr_eof,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    output logic                td_valid,
    input  logic                td_ready,
    output logic [WORDS*DW-1:0] td_desc,
    output logic [CH_W-1:0]     td_chan,
    output logic [QW-1:0]       td_queue,
    output logic                atomic_err
);
    logic                wr_fire, out_busy;
    logic [WW-1:0]       a_word;
    logic [SW-1:0]       a_set, cur_set;
    logic [CH_W-1:0]     a_chan, cur_chan;
    logic                atomic_ok, atomic_bad, staged_go, launch;
    logic [SETS-1:0][WORDS*DW-1:0] bank_img;
    logic [WORDS*DW-1:0] launch_desc;

    assign a_word   = wr_addr[WW-1:0];
    assign a_set    = wr_addr[WW+SW-1:WW];
    assign a_chan   = wr_addr[AW-1:WW+SW];
    assign wr_ready = !out_busy;
    assign wr_fire  = wr_valid && wr_ready;

    tr_sub_burst #(.SW(SW), .CH_W(CH_W), .WW(WW), .WORDS(WORDS)) u_burst (
        .clk(clk), .rst_n(rst_n), .fire(wr_fire), .sof(wr_sof), .eof(wr_eof),
        .set_in(a_set), .chan_in(a_chan), .word_in(a_word),
        .set_o(cur_set), .chan_o(cur_chan),
        .atomic_ok(atomic_ok), .atomic_bad(atomic_bad), .err_o(atomic_err)
    );

    for (genvar s = 0; s < SETS; s++) begin : g_bank
        logic we_s, clr_s;
        assign we_s = wr_fire && (cur_set == SW'(s));
        if (s == ATOMIC_SET) begin : g_atomic
            assign clr_s = we_s && wr_eof;
        end else begin : g_staged
            assign clr_s = we_s && (a_word == '0);
        end
        tr_sub_bank #(.DW(DW), .WORDS(WORDS), .WW(WW)) u_bank (
            .clk(clk), .rst_n(rst_n), .we(we_s), .clr(clr_s),
            .word(a_word), .data(wr_data), .image(bank_img[s])
        );
    end

    always_comb begin
        staged_go   = wr_fire && (cur_set != SW'(ATOMIC_SET)) && (a_word == '0);
        launch      = staged_go || atomic_ok;
        launch_desc = '0;
        if (32'(cur_set) < SETS) launch_desc = bank_img[cur_set];
    end

    tr_sub_out #(.DW(DW), .WORDS(WORDS), .CH_W(CH_W), .NUM_Q(NUM_Q), .QW(QW)) u_out (
        .clk(clk), .rst_n(rst_n), .load(launch), .desc(launch_desc), .chan(cur_chan),
        .td_ready(td_ready), .td_valid(td_valid), .td_desc(td_desc),
        .td_chan(td_chan), .td_queue(td_queue), .busy(out_busy)
    );
endmodule

// File: rtl/tr_submit_regs_chk.sv
module tr_submit_regs_chk #(
    parameter int unsigned DW    = 32,
    parameter int unsigned WORDS = 16,
    parameter int unsigned CH_W  = 4,
    parameter int unsigned NUM_Q = 5,
    parameter int unsigned SW    = 2,
    parameter int unsigned QW    = 3,
    localparam int unsigned WW   = $clog2(WORDS),
    localparam int unsigned AW   = CH_W + SW + WW
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_valid,
    input logic                wr_ready,
    input logic                wr_sof,
    input logic                wr_eof,
    input logic [AW-1:0]       wr_addr,
    input logic [DW-1:0]       wr_data,
    input logic                td_valid,
    input logic                td_ready,
    input logic [WORDS*DW-1:0] td_desc,
    input logic [CH_W-1:0]     td_chan,
    input logic [QW-1:0]       td_queue,
    input logic                atomic_err
);
    logic sof_trigger;
    assign sof_trigger = wr_valid && wr_ready && wr_sof
                         && (wr_addr[WW+SW-1:WW] != '0) && (wr_addr[WW-1:0] == '0);

    p_stall_blocks_writes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (td_valid && !td_ready) |-> !wr_ready);

    p_stall_holds_output_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (td_valid && !td_ready) |=> (td_valid && $stable(td_desc)
                                     && $stable(td_chan) && $stable(td_queue)));

    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        atomic_err |=> atomic_err);

    p_err_on_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(atomic_err) |-> $past(wr_valid && wr_ready && wr_eof));

    p_queue_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        td_valid |-> (32'(td_queue) < NUM_Q));

    p_trigger_next_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sof_trigger |=> (td_valid && td_desc[DW-1:0] == $past(wr_data)
                         && td_chan == $past(wr_addr[AW-1:WW+SW])));
endmodule

bind tr_submit_regs tr_submit_regs_chk u_chk (.*);

// File: tb/sim_tr_submit_regs.sv
module sim_tr_submit_regs;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_valid = 1'b0, wr_sof = 1'b0, wr_eof = 1'b0;
    logic [9:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic         wr_ready, td_valid, atomic_err;
    logic         td_ready = 1'b1;
    logic [511:0] td_desc;
    logic [3:0]   td_chan;
    logic [2:0]   td_queue;

    int compared = 0, mismatched = 0, cyc = 0;
    int rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    string phase = "R1";
    bit done = 0;

    always #4 clk = ~clk;

    tr_submit_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_sof(wr_sof), .wr_eof(wr_eof), .wr_addr(wr_addr), .wr_data(wr_data),
        .td_valid(td_valid), .td_ready(td_ready), .td_desc(td_desc),
        .td_chan(td_chan), .td_queue(td_queue), .atomic_err(atomic_err)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0]  mb [4][16];
    int           m_mask;
    bit           m_open, m_valid, m_err;
    int           m_set, m_chan, o_chan;
    logic [511:0] o_desc;

    function automatic logic [511:0] pack_set(int s);
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[32*i +: 32] = mb[s][i];
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 4; s++) for (int i = 0; i < 16; i++) mb[s][i] = 0;
            m_mask = 0; m_open = 0; m_valid = 0; m_err = 0; m_set = 0; m_chan = 0;
            o_chan = 0; o_desc = '0;
        end else begin
            bit acc, st;
            int s, c, w;
            acc = wr_valid && (!m_valid || td_ready);
            if (m_valid && td_ready) m_valid = 0;
            if (acc) begin
                st = wr_sof || !m_open;
                s = st ? int'(wr_addr[5:4]) : m_set;
                c = st ? int'(wr_addr[9:6]) : m_chan;
                w = int'(wr_addr[3:0]);
                mb[s][w] = wr_data;
                if (s == 0) begin
                    if (st) m_mask = 0;
                    m_mask = m_mask | (1 << w);
                end
                if (s != 0 && w == 0) begin
                    o_desc = pack_set(s); o_chan = c; m_valid = 1;
                    for (int i = 0; i < 16; i++) mb[s][i] = 0;
                end
                if (wr_eof) begin
                    if (s == 0) begin
                        if (m_mask == 16'hFFFF) begin
                            o_desc = pack_set(0); o_chan = c; m_valid = 1;
                        end else m_err = 1;
                        for (int i = 0; i < 16; i++) mb[0][i] = 0;
                        m_mask = 0;
                    end
                    m_open = 0;
                end else begin
                    m_open = 1; m_set = s; m_chan = c;
                end
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    task automatic note(bit ok, string what, logic [511:0] act, logic [511:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", phase, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #3;
        if (rst_n && !done) begin
            note(td_valid == m_valid, "td_valid", 512'(td_valid), 512'(m_valid));
            note(wr_ready == (!m_valid || td_ready), "wr_ready", 512'(wr_ready), 512'(!m_valid || td_ready));
            note(atomic_err == m_err, "atomic_err", 512'(atomic_err), 512'(m_err));
            if (m_valid) begin
                note(td_desc == o_desc, "td_desc", td_desc, o_desc);
                note(int'(td_chan) == o_chan, "td_chan", 512'(td_chan), 512'(o_chan));
                note(int'(td_queue) == o_chan % 5, "td_queue", 512'(td_queue), 512'(o_chan % 5));
            end
        end
    end

    // downstream ready pattern
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0: td_ready <= 1'b1;
            1: td_ready <= 1'b0;
            default: td_ready <= lfsr[3];
        endcase
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            mismatched++; compared++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(int chan, int set, int word, logic [31:0] data, bit sof, bit eof);
        @(negedge clk);
        wr_valid = 1; wr_sof = sof; wr_eof = eof; wr_data = data;
        wr_addr = {chan[3:0], set[1:0], word[3:0]};
        #3;
        while (!wr_ready) begin @(negedge clk); #3; end
    endtask

    task automatic idle(int n);
        @(negedge clk);
        wr_valid = 0; wr_sof = 0; wr_eof = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic atomic_full(int chan, int off, logic [31:0] base);
        for (int k = 0; k < 16; k++)
            wr(chan, 0, (k * 7 + off) % 16, base + k, k == 0, k == 15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #3;
        // R1: reset values
        note(td_valid == 0, "R1 td_valid", 512'(td_valid), 0);
        note(atomic_err == 0, "R1 atomic_err", 512'(atomic_err), 0);
        note(wr_ready == 1, "R1 wr_ready", 512'(wr_ready), 1);
        @(negedge clk); rst_n = 1;
        idle(2);

        phase = "R3"; // complete atomic bursts, permuted order and repeated words
        atomic_full(7, 3, 32'h1000_0000);
        idle(2);
        wr(2, 0, 5, 32'hDEAD0005, 1, 0);
        for (int k = 0; k < 16; k++) wr(2, 0, k, 32'h2000 + k, 0, k == 15);
        idle(2);

        phase = "R4"; // atomic burst closed with words missing
        for (int k = 0; k < 10; k++) wr(3, 0, k, 32'h3000 + k, k == 0, k == 9);
        idle(2);
        #3;
        note(atomic_err == 1, "R4 sticky error set", 512'(atomic_err), 1);
        note(td_valid == 0, "R4 no descriptor", 512'(td_valid), 0);
        atomic_full(4, 1, 32'h4400_0000);
        idle(2);
        #3;
        note(atomic_err == 1, "R4 error still set", 512'(atomic_err), 1);

        phase = "R5"; // staged set filled over three bursts, then trigger
        for (int k = 1; k < 6; k++) wr(9, 1, k, 32'h5100 + k, k == 1, k == 5);
        idle(3);
        for (int k = 6; k < 11; k++) wr(9, 1, k, 32'h5200 + k, k == 6, k == 10);
        wr(9, 1, 3, 32'h5333, 1, 1);
        idle(1);
        wr(11, 1, 0, 32'h5000_0000, 1, 1);
        idle(2);

        phase = "R6"; // next launch after clear carries zeros elsewhere
        wr(12, 1, 3, 32'h6003, 1, 0);
        wr(12, 1, 0, 32'h6000, 0, 1);
        idle(2);

        phase = "R10"; // interleaved staged sets
        wr(1, 2, 4, 32'hA204, 1, 1);
        wr(1, 3, 4, 32'hA304, 1, 1);
        wr(1, 2, 9, 32'hA209, 1, 1);
        wr(6, 3, 0, 32'hA300, 1, 1);
        wr(5, 2, 0, 32'hA200, 1, 1);
        idle(2);

        phase = "R2"; // later writes of a burst carry other set/channel bits
        wr(13, 2, 7, 32'hB207, 1, 0);
        wr(0, 0, 8, 32'hB208, 0, 0);
        wr(4, 3, 0, 32'hB200, 0, 1);
        wr(8, 1, 2, 32'hB102, 0, 0);  // no sof and burst closed: starts a burst
        wr(3, 0, 0, 32'hB100, 0, 1);
        idle(2);

        phase = "R9"; // back-to-back launches
        for (int k = 0; k < 6; k++) wr(k, 1 + k % 3, 0, 32'h9000 + k, 1, 1);
        idle(2);

        phase = "R8"; // downstream stalled
        rdy_mode = 1;
        wr(10, 2, 0, 32'h8000_0001, 1, 1);
        @(negedge clk); wr_addr = {4'd14, 2'd3, 4'd0}; wr_data = 32'h8000_0002;
        wr_sof = 1; wr_eof = 1;
        repeat (4) begin
            @(negedge clk); #3;
            note(wr_ready == 0, "R8 wr_ready low while stalled", 512'(wr_ready), 0);
        end
        rdy_mode = 0;
        #3;
        while (!wr_ready) begin @(negedge clk); #3; end
        idle(3);

        phase = "R7"; // every channel through the queue map
        for (int ch = 0; ch < 16; ch++) wr(ch, 3, 0, 32'h7000 + ch, 1, 1);
        idle(2);

        phase = "R3/R5 random"; // mixed traffic with random downstream ready
        rdy_mode = 2;
        for (int b = 0; b < 400; b++) begin
            int ch, st, len;
            ch = $urandom % 16; st = $urandom % 4;
            if (st == 0 && ($urandom % 2) == 1) atomic_full(ch, $urandom % 16, $urandom);
            else begin
                len = 1 + $urandom % 5;
                for (int k = 0; k < len; k++)
                    wr(ch, st, $urandom % 16, $urandom, k == 0, k == len - 1);
            end
            if ($urandom % 4 == 0) idle($urandom % 3);
        end
        rdy_mode = 0;
        idle(4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule